// File: doc/BRIEF.md
# Transmitter Coefficient Legality Checker

This block checks a requested three-tap transmitter equalizer setting before the setting reaches the driver. A setting has three taps: a pre-shoot tap, a main (boost) tap and a de-emphasis tap. The checker compares them with the configured full-swing value `fs_i` and low-frequency limit `lf_i`. The pre-shoot and de-emphasis taps arrive either as two's-complement values or as plain magnitudes. The main tap is always an unsigned magnitude.

Three arithmetic rules are applied:
- The pre-shoot magnitude must not exceed floor(FS/4).
- The sum of the three magnitudes must equal FS exactly.
- The main tap, less both side-tap magnitudes, must be at least LF.

One cycle after the request, the block reports accept or reject together with a separate flag for each failed rule. When a setting is accepted, its tap magnitudes are registered. They then drive the transmitter and are echoed in the outgoing training sets. A rejected setting leaves the applied taps as they were. The checker takes a new request every cycle.

Top module: `txeq_coef_check`

## Requirements
- R1: With `req_signed_i`=1, `req_pre_i` and `req_post_i` are 7-bit two's complement and their magnitude is the absolute value (-64 gives 64). With `req_signed_i`=0, only bits [5:0] are used and bit 6 is ignored.
- R2: Bit 0 of `res_viol_o` is set when the pre-shoot magnitude is greater than floor(`fs_i`/4). A magnitude equal to the floor passes.
- R3: Bit 1 of `res_viol_o` is set when pre magnitude + `req_main_i` + post magnitude differs from `fs_i`. The sum is formed wide enough that it can never wrap.
- R4: Bit 2 of `res_viol_o` is set when `req_main_i` - pre magnitude - post magnitude is below `lf_i`. A negative difference fails, and equality passes.
- R5: `res_accept_o` is 1 exactly when all three bits of `res_viol_o` are 0.
- R6: `res_valid_o` is high exactly one cycle after `req_valid_i` is high, also for requests on consecutive cycles. `res_accept_o` and `res_viol_o` hold their values in cycles without a request.
- R7: On accept, `app_pre_o`, `app_main_o` and `app_post_o` take the request's magnitudes in the same cycle that `res_valid_o` rises.
- R8: On a reject, or when there is no request, the applied tap outputs keep their values.
- R9: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request qualifier |
| req_signed_i | input | 1 | 1: side taps in two's complement; 0: side taps as magnitudes |
| req_pre_i | input | 7 | Pre-shoot tap |
| req_main_i | input | 6 | Main (boost) tap magnitude |
| req_post_i | input | 7 | De-emphasis tap |
| fs_i | input | 6 | Full-swing value |
| lf_i | input | 6 | Low-frequency limit |
| res_valid_o | output | 1 | Result valid |
| res_accept_o | output | 1 | Setting legal and applied |
| res_viol_o | output | 3 | Failed-rule flags: bit 0 pre limit, bit 1 sum, bit 2 boost margin |
| app_pre_o | output | 7 | Applied pre-shoot magnitude |
| app_main_o | output | 6 | Applied main magnitude |
| app_post_o | output | 7 | Applied de-emphasis magnitude |

## Verification
Every result is due at the first rising edge after the request. This covers the valid, accept and flag outputs and the update of the applied taps. Requests are driven one time unit after a rising edge, so the bench reads each result one time unit after the next rising edge. That keeps reads clear of the edge. The model's expected values are taken at that same point. Idle cycles are checked in the same way to confirm that the valid bit drops and that the result and applied taps hold.

// File: rtl/txeq_pkg.sv
package txeq_pkg;
  localparam int unsigned COEF_W  = 6;
  localparam int unsigned N_RULES = 3;
  localparam int unsigned N_SIDE  = 2;

  localparam int unsigned VIOL_PRE   = 0;
  localparam int unsigned VIOL_SUM   = 1;
  localparam int unsigned VIOL_BOOST = 2;

  localparam int unsigned SIDE_PRE  = 0;
  localparam int unsigned SIDE_POST = 1;
endpackage

// File: rtl/txeq_tap_mag.sv
module txeq_tap_mag #(
  parameter int unsigned CW = 6
) (
  input  logic        signed_mode_i,
  input  logic [CW:0] raw_i,
  output logic [CW:0] mag_o
);
  logic [CW:0] neg_val;

  assign neg_val = (~raw_i) + 1'b1;

  always_comb begin
    if (signed_mode_i) begin
      mag_o = raw_i[CW] ? neg_val : raw_i;
    end else begin
      mag_o = {1'b0, raw_i[CW-1:0]};
    end
  end
endmodule

// File: rtl/txeq_rule_eval.sv
module txeq_rule_eval
  import txeq_pkg::*;
#(
  parameter int unsigned CW = COEF_W
) (
  input  logic [CW:0]        pre_mag_i,
  input  logic [CW-1:0]      main_i,
  input  logic [CW:0]        post_mag_i,
  input  logic [CW-1:0]      fs_i,
  input  logic [CW-1:0]      lf_i,
  output logic [N_RULES-1:0] viol_o
);
  localparam int unsigned SW = CW + 3;

  logic [SW-1:0] pre_w, main_w, post_w, fs_w, lf_w;
  logic [SW-1:0] fs_quarter, tap_sum, side_plus_lf;

  assign pre_w  = SW'(pre_mag_i);
  assign main_w = SW'(main_i);
  assign post_w = SW'(post_mag_i);
  assign fs_w   = SW'(fs_i);
  assign lf_w   = SW'(lf_i);

  assign fs_quarter   = fs_w >> 2;
  assign tap_sum      = pre_w + main_w + post_w;
  // boost margin compared without subtraction so a negative margin cannot wrap
  assign side_plus_lf = lf_w + pre_w + post_w;

  always_comb begin
    viol_o             = '0;
    viol_o[VIOL_PRE]   = pre_w > fs_quarter;
    viol_o[VIOL_SUM]   = tap_sum != fs_w;
    viol_o[VIOL_BOOST] = main_w < side_plus_lf;
  end
endmodule

// File: rtl/txeq_result_reg.sv
module txeq_result_reg
  import txeq_pkg::*;
#(
  parameter int unsigned CW = COEF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  logic [N_RULES-1:0] in_viol_i,
  input  logic [CW:0]        in_pre_i,
  input  logic [CW-1:0]      in_main_i,
  input  logic [CW:0]        in_post_i,
  output logic               res_valid_o,
  output logic               res_accept_o,
  output logic [N_RULES-1:0] res_viol_o,
  output logic [CW:0]        app_pre_o,
  output logic [CW-1:0]      app_main_o,
  output logic [CW:0]        app_post_o
);
  logic legal;

  assign legal = ~|in_viol_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o  <= 1'b0;
      res_accept_o <= 1'b0;
      res_viol_o   <= '0;
    end else begin
      res_valid_o <= in_valid_i;
      if (in_valid_i) begin
        res_accept_o <= legal;
        res_viol_o   <= in_viol_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      app_pre_o  <= '0;
      app_main_o <= '0;
      app_post_o <= '0;
    end else if (in_valid_i && legal) begin
      app_pre_o  <= in_pre_i;
      app_main_o <= in_main_i;
      app_post_o <= in_post_i;
    end
  end
endmodule

// File: rtl/txeq_coef_check.sv
module txeq_coef_check
  import txeq_pkg::*;
#(
  parameter int unsigned CW = COEF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               req_signed_i,
  input  logic [CW:0]        req_pre_i,
  input  logic [CW-1:0]      req_main_i,
  input  logic [CW:0]        req_post_i,
  input  logic [CW-1:0]      fs_i,
  input  logic [CW-1:0]      lf_i,
  output logic               res_valid_o,
  output logic               res_accept_o,
  output logic [N_RULES-1:0] res_viol_o,
  output logic [CW:0]        app_pre_o,
  output logic [CW-1:0]      app_main_o,
  output logic [CW:0]        app_post_o
);
  localparam int unsigned SW = CW + 3;

  logic [CW:0]        side_raw [N_SIDE];
  logic [CW:0]        side_mag [N_SIDE];
  logic [N_RULES-1:0] viol;

  assign side_raw[SIDE_PRE]  = req_pre_i;
  assign side_raw[SIDE_POST] = req_post_i;

  for (genvar g = 0; g < N_SIDE; g++) begin : g_side
    txeq_tap_mag #(.CW(CW)) u_mag (
      .signed_mode_i(req_signed_i),
      .raw_i        (side_raw[g]),
      .mag_o        (side_mag[g])
    );
  end

  txeq_rule_eval #(.CW(CW)) u_rules (
    .pre_mag_i (side_mag[SIDE_PRE]),
    .main_i    (req_main_i),
    .post_mag_i(side_mag[SIDE_POST]),
    .fs_i      (fs_i),
    .lf_i      (lf_i),
    .viol_o    (viol)
  );

  txeq_result_reg #(.CW(CW)) u_res (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (req_valid_i),
    .in_viol_i   (viol),
    .in_pre_i    (side_mag[SIDE_PRE]),
    .in_main_i   (req_main_i),
    .in_post_i   (side_mag[SIDE_POST]),
    .res_valid_o (res_valid_o),
    .res_accept_o(res_accept_o),
    .res_viol_o  (res_viol_o),
    .app_pre_o   (app_pre_o),
    .app_main_o  (app_main_o),
    .app_post_o  (app_post_o)
  );

  a_r6_valid_lat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> res_valid_o);

  a_r6_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !res_valid_o);

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(res_valid_o && res_accept_o) |->
      ($stable(app_pre_o) && $stable(app_main_o) && $stable(app_post_o)));

  a_r7_take_main: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (res_accept_o -> (app_main_o == $past(req_main_i))));

  a_r3_sum_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (res_accept_o ->
      ((SW'(app_pre_o) + SW'(app_main_o) + SW'(app_post_o)) == SW'($past(fs_i)))));

  a_r2_pre_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (res_accept_o -> (SW'(app_pre_o) <= SW'($past(fs_i) >> 2))));
endmodule

// File: tb/txeq_coef_check_tb.sv
module txeq_coef_check_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_signed = 1'b0;
  logic [6:0] req_pre = '0, req_post = '0;
  logic [5:0] req_main = '0, fs = '0, lf = '0;
  logic       res_valid, res_accept;
  logic [2:0] res_viol;
  logic [6:0] app_pre, app_post;
  logic [5:0] app_main;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic       e_acc = 1'b0;
  logic [2:0] e_viol = '0;
  int         e_pre = 0, e_main = 0, e_post = 0;

  always #10 clk = ~clk;

  txeq_coef_check u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_signed_i(req_signed),
    .req_pre_i(req_pre), .req_main_i(req_main), .req_post_i(req_post),
    .fs_i(fs), .lf_i(lf), .res_valid_o(res_valid), .res_accept_o(res_accept),
    .res_viol_o(res_viol), .app_pre_o(app_pre), .app_main_o(app_main), .app_post_o(app_post)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mag(input bit sg, input logic [6:0] v);
    if (!sg) return int'(v[5:0]);
    if (v[6]) return 128 - int'(v);
    return int'(v);
  endfunction

  task automatic check_all(input string tag, input bit exp_valid);
    chk({tag, " R6 valid"}, int'(res_valid), int'(exp_valid));
    chk({tag, " R5 accept"}, int'(res_accept), int'(e_acc));
    chk({tag, " R2/R3/R4 viol"}, int'(res_viol), int'(e_viol));
    chk({tag, " R7/R8 pre"}, int'(app_pre), e_pre);
    chk({tag, " R7/R8 main"}, int'(app_main), e_main);
    chk({tag, " R7/R8 post"}, int'(app_post), e_post);
  endtask

  task automatic req(input string tag, input bit sg, input logic [6:0] p,
                     input logic [5:0] m, input logic [6:0] q,
                     input logic [5:0] f, input logic [5:0] l);
    int pm, qm;
    pm = mag(sg, p);
    qm = mag(sg, q);
    req_valid = 1'b1; req_signed = sg; req_pre = p; req_main = m;
    req_post = q; fs = f; lf = l;
    e_viol[0] = pm > (int'(f) / 4);
    e_viol[1] = (pm + int'(m) + qm) != int'(f);
    e_viol[2] = (int'(m) - pm - qm) < int'(l);
    e_acc = (e_viol == 3'b000);
    if (e_acc) begin e_pre = pm; e_main = int'(m); e_post = qm; end
    @(posedge clk); #1;
    req_valid = 1'b0;
    check_all(tag, 1'b1);
  endtask

  task automatic idle(input string tag);
    req_valid = 1'b0;
    req_pre = 7'h3F; req_main = 6'h3F; req_post = 7'h3F;
    @(posedge clk); #1;
    check_all(tag, 1'b0);
  endtask

  task automatic t_reset;
    #5;
    chk("R9 valid", int'(res_valid), 0);
    chk("R9 accept", int'(res_accept), 0);
    chk("R9 viol", int'(res_viol), 0);
    chk("R9 taps", int'(app_pre) + int'(app_main) + int'(app_post), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    check_all("R9 after release", 1'b0);
  endtask

  task automatic t_legal;
    req("R5 legal", 1'b0, 7'd4, 6'd28, 7'd8, 6'd40, 6'd10);
    idle("R8 idle after legal");
  endtask

  task automatic t_rule_a;
    req("R2 pre at floor", 1'b0, 7'd10, 6'd30, 7'd0, 6'd40, 6'd10);
    req("R2 pre over floor", 1'b0, 7'd11, 6'd29, 7'd0, 6'd40, 6'd10);
    req("R2 floor rounding", 1'b0, 7'd10, 6'd32, 7'd1, 6'd43, 6'd10);
  endtask

  task automatic t_rule_b;
    req("R3 sum short", 1'b0, 7'd4, 6'd27, 7'd8, 6'd40, 6'd10);
    req("R3 no wrap", 1'b0, 7'd0, 6'd63, 7'd1, 6'd0, 6'd0);
    req("R3 all max", 1'b0, 7'd63, 6'd63, 7'd63, 6'd63, 6'd0);
  endtask

  task automatic t_rule_c;
    req("R4 margin low", 1'b0, 7'd5, 6'd27, 7'd8, 6'd40, 6'd20);
    req("R4 margin equal", 1'b0, 7'd5, 6'd33, 7'd8, 6'd46, 6'd20);
    req("R4 negative margin", 1'b0, 7'd2, 6'd3, 7'd5, 6'd10, 6'd0);
  endtask

  task automatic t_signed;
    req("R1 signed negatives", 1'b1, 7'h7C, 6'd28, 7'h78, 6'd40, 6'd10);
    req("R1 signed -64", 1'b1, 7'h40, 6'd0, 7'd0, 6'd63, 6'd0);
    req("R1 mag bit6 ignored", 1'b0, 7'h45, 6'd30, 7'h49, 6'd44, 6'd10);
    req("R1 signed positive", 1'b1, 7'd3, 6'd20, 7'd1, 6'd24, 6'd5);
  endtask

  task automatic t_b2b;
    req("R6 b2b accept", 1'b0, 7'd2, 6'd18, 7'd4, 6'd24, 6'd6);
    req("R6 b2b reject", 1'b0, 7'd9, 6'd11, 7'd4, 6'd24, 6'd6);
    req("R6 b2b accept2", 1'b0, 7'd1, 6'd20, 7'd3, 6'd24, 6'd6);
    idle("R6 idle holds 1");
    idle("R6 idle holds 2");
  endtask

  initial begin
    t_reset();
    t_legal();
    t_rule_a();
    t_rule_b();
    t_rule_c();
    t_signed();
    t_b2b();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule